// File: doc/BRIEF.md
# Receiver Link Training Sequencer

This block steps a serial receiver through bring-up. It runs a fixed order of phases: coarse frequency acquisition, phase lock, offset calibration, equalizer peaking sweep, decision-feedback adaptation, fine tuning and error-rate verification. It then hands the link over to blind background tracking. Only one subordinate engine is enabled at a time. Each engine reports done or fail for its own phase. A programmable per-phase watchdog bounds how long the block waits for that report.

Once the link is up, the adaptation engines are told to run in blind mode, which uses reduced step sizes, and `link_up_o` is raised. A retrain request re-runs the whole sequence, but only once the link is up or has failed. A re-initialization request is the severe case: from any state it restarts at frequency acquisition. A failed verification returns to the peaking sweep, up to a programmable number of retries.

Top module: `rx_train_seq`

## Requirements
- R1: After reset all enables are low, `link_up_o` and `mode_o` are 0, and `status_o` is 5'b00_000 (class 00 = idle).
- R2: `start_i` moves the block from idle to frequency acquisition, and `status_o` becomes 5'b01_000. `start_i` has no effect in any other state.
- R3: A training phase advances to the next phase one cycle after the `done_i` bit of the current phase is sampled high. Done bits of other phases have no effect.
- R4: At most one bit of `en_o` is high. Bit p is high exactly while phase p runs, with 0 = frequency, 1 = phase lock, 2 = offset, 3 = peaking sweep, 4 = feedback adaptation, 5 = fine tune, 6 = verify. During training, `status_o` = {2'b01, p}.
- R5: `ctle_hold_o` is high only during the feedback-adaptation phase. That phase is entered only from the peaking-sweep phase.
- R6: When verify is done, the block enters tracking. In tracking, `link_up_o` = 1, `mode_o` = 1 (blind), `en_o` = 0 and `status_o` = 5'b01_111.
- R7: A phase with limit L waits L+1 cycles. If neither done nor fail is seen by then, the block enters the failed state with `status_o` = {2'b10, p}. A done in the last cycle still advances.
- R8: A fail report in phases 0 to 5 enters the failed state with `status_o` = {2'b11, p}. A fail report wins over a done in the same cycle.
- R9: A verify fail with fewer than `retry_lim_i` retries used so far goes back to the peaking sweep and uses one retry. Once the retries are used up, a verify fail gives `status_o` = 5'b11_110.
- R10: `retrain_i` is acted on only in tracking or in the failed state. It goes to frequency acquisition and clears the retry count. During training it has no effect.
- R11: `reinit_i` goes to frequency acquisition from any state. It has priority over all other inputs and restarts the phase timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin training from idle |
| retrain_i | input | 1 | Re-run training (acted on only after link-up or failure) |
| reinit_i | input | 1 | Restart from frequency acquisition from any state |
| done_i | input | 7 | Per-phase completion reports |
| fail_i | input | 7 | Per-phase failure reports |
| tmo_lim_i | input | 7*TW | Per-phase timeout limit, phase p in bits [p*TW +: TW] |
| retry_lim_i | input | RW | Allowed verification retries |
| en_o | output | 7 | Per-phase engine enable |
| ctle_hold_o | output | 1 | Freeze peaking setting during feedback adaptation |
| mode_o | output | 1 | 0 = training adaptation, 1 = blind tracking |
| link_up_o | output | 1 | Link declared up |
| status_o | output | 5 | {class, phase} status code |

## Verification
The bench targets the last-cycle race between done and timeout. A design that is off by one would either fail a phase that reported in time or give it an extra cycle. It checks that reports for other phases and mid-training retrain requests are ignored; a design that decodes the wrong bit would skip phases. The retry path is driven until the retries run out, and again after a retrain. This catches a counter that never clears or that allows one retry too many. A re-initialization inside frequency acquisition must restart that phase's watchdog, or the timeout would come early.

// File: rtl/rx_train_pkg.sv
// Shared types for the receiver training sequencer.
// Assumes the phase count is fixed at seven training phases plus tracking.
package rx_train_pkg;
    localparam int NPH = 7;

    typedef enum logic [3:0] {
        S_IDLE   = 4'd0,
        S_FREQ   = 4'd1,
        S_PLOCK  = 4'd2,
        S_OFFS   = 4'd3,
        S_CTLE   = 4'd4,
        S_DFE    = 4'd5,
        S_FINE   = 4'd6,
        S_VERIFY = 4'd7,
        S_TRACK  = 4'd8,
        S_FAIL   = 4'd9
    } state_t;

    localparam logic [1:0] CL_IDLE  = 2'b00;
    localparam logic [1:0] CL_TRAIN = 2'b01;
    localparam logic [1:0] CL_TMO   = 2'b10;
    localparam logic [1:0] CL_FAIL  = 2'b11;
endpackage

// File: rtl/rx_phase_timer.sv
// Per-phase watchdog counter. Clears on restart, counts while a phase runs,
// and flags expiry when the count reaches the selected limit.
// Assumes the limit is stable for the duration of a phase.
module rx_phase_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          run_i,
    input  logic [TW-1:0] lim_i,
    output logic          expired_o
);
    logic [TW-1:0] cnt_q;

    // Count cycles spent in the current phase, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (restart_i)              cnt_q <= '0;
        else if (run_i && cnt_q != lim_i) cnt_q <= cnt_q + 1'b1;
    end

    // Expiry is visible only while a phase is running.
    always_comb expired_o = run_i && (cnt_q == lim_i);
endmodule

// File: rtl/rx_retry_ctr.sv
// Counts verification retries; reports when the allowed number is used up.
// Assumes clear and increment are never requested in the same cycle.
module rx_retry_ctr #(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          inc_i,
    input  logic [RW-1:0] lim_i,
    output logic          exhausted_o
);
    logic [RW-1:0] cnt_q;

    // Track retries used since the last sequence start.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (inc_i)   cnt_q <= cnt_q + 1'b1;
    end

    // No retry left once the count has reached the limit.
    always_comb exhausted_o = (cnt_q >= lim_i);
endmodule

// File: rtl/rx_phase_decode.sv
// Decodes the sequencer state into engine enables, mode, link flag and status.
// Assumes the failure code is loaded whenever the failed state is entered.
module rx_phase_decode
    import rx_train_pkg::*;
(
    input  state_t         st_i,
    input  logic [4:0]     fail_code_i,
    output logic [NPH-1:0] en_o,
    output logic           ctle_hold_o,
    output logic           mode_o,
    output logic           link_up_o,
    output logic [4:0]     status_o
);
    // One enable per training phase, from the state encoding.
    for (genvar g = 0; g < NPH; g++) begin : g_en
        always_comb en_o[g] = (st_i == state_t'(4'(g + 1)));
    end

    // Mode, hold and link flags, plus the status code.
    always_comb begin
        ctle_hold_o = (st_i == S_DFE);
        mode_o      = (st_i == S_TRACK);
        link_up_o   = (st_i == S_TRACK);
        case (st_i)
            S_IDLE:  status_o = {CL_IDLE, 3'd0};
            S_TRACK: status_o = {CL_TRAIN, 3'd7};
            S_FAIL:  status_o = fail_code_i;
            default: status_o = {CL_TRAIN, 3'(st_i - 4'd1)};
        endcase
    end
endmodule

// File: rtl/rx_train_seq.sv
// Receiver link training sequencer top. Walks seven training phases in a
// fixed order, then enters tracking. It handles start, retrain and reinit
// requests, per-phase timeouts and verification retries.
// Assumes done/fail inputs are synchronous to clk.
module rx_train_seq
    import rx_train_pkg::*;
#(
    parameter int TW = 16,
    parameter int RW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            retrain_i,
    input  logic            reinit_i,
    input  logic [6:0]      done_i,
    input  logic [6:0]      fail_i,
    input  logic [7*TW-1:0] tmo_lim_i,
    input  logic [RW-1:0]   retry_lim_i,
    output logic [6:0]      en_o,
    output logic            ctle_hold_o,
    output logic            mode_o,
    output logic            link_up_o,
    output logic [4:0]      status_o
);
    state_t        st_q, st_d;
    logic [4:0]    code_q, code_d;
    logic          code_ld;
    logic [3:0]    st_m1;
    logic [2:0]    pidx;
    logic [7:0]    done_x, fail_x;
    logic          in_phase;
    logic [TW-1:0] lim_sel;
    logic          expired, exhausted, retry_inc, retry_clr, restart;

    // Phase index and padded report vectors.
    always_comb begin
        st_m1    = st_q - 4'd1;
        pidx     = st_m1[2:0];
        in_phase = (st_q >= S_FREQ) && (st_q <= S_VERIFY);
        done_x   = {1'b0, done_i};
        fail_x   = {1'b0, fail_i};
        lim_sel  = in_phase ? tmo_lim_i[pidx*TW +: TW] : '0;
    end

    // Next-state selection with reinit as the top priority.
    always_comb begin
        st_d      = st_q;
        code_d    = code_q;
        code_ld   = 1'b0;
        retry_inc = 1'b0;
        if (reinit_i) begin
            st_d = S_FREQ;
        end else begin
            case (st_q)
                S_IDLE:         if (start_i)   st_d = S_FREQ;
                S_TRACK, S_FAIL: if (retrain_i) st_d = S_FREQ;
                default: begin
                    if (fail_x[pidx]) begin
                        if (st_q == S_VERIFY && !exhausted) begin
                            st_d      = S_CTLE;
                            retry_inc = 1'b1;
                        end else begin
                            st_d    = S_FAIL;
                            code_d  = {CL_FAIL, pidx};
                            code_ld = 1'b1;
                        end
                    end else if (done_x[pidx]) begin
                        st_d = (st_q == S_VERIFY) ? S_TRACK : state_t'(st_q + 4'd1);
                    end else if (expired) begin
                        st_d    = S_FAIL;
                        code_d  = {CL_TMO, pidx};
                        code_ld = 1'b1;
                    end
                end
            endcase
        end
        restart   = (st_d != st_q) || reinit_i;
        retry_clr = (st_d == S_FREQ);
    end

    // State and failure-code registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            code_q <= '0;
        end else begin
            st_q <= st_d;
            if (code_ld) code_q <= code_d;
        end
    end

    rx_phase_timer #(.TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .run_i     (in_phase),
        .lim_i     (lim_sel),
        .expired_o (expired)
    );

    rx_retry_ctr #(.RW(RW)) u_retry (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (retry_clr),
        .inc_i       (retry_inc),
        .lim_i       (retry_lim_i),
        .exhausted_o (exhausted)
    );

    rx_phase_decode u_dec (
        .st_i        (st_q),
        .fail_code_i (code_q),
        .en_o        (en_o),
        .ctle_hold_o (ctle_hold_o),
        .mode_o      (mode_o),
        .link_up_o   (link_up_o),
        .status_o    (status_o)
    );
endmodule

// File: rtl/rx_train_seq_chk.sv
// Protocol checker for the training sequencer, bound to the top module.
module rx_train_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reinit_i,
    input logic [6:0] done_i,
    input logic [6:0] fail_i,
    input logic [6:0] en_o,
    input logic       mode_o,
    input logic       link_up_o
);
    // R4
    en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_o));

    // R11
    reinit_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_i |=> (en_o == 7'b000_0001));

    // R6
    link_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up_o) |-> ($past(en_o[6]) && $past(done_i[6]) && !$past(fail_i[6])));

    // R6
    track_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_up_o |-> (mode_o && en_o == 7'b0));

    // R5
    dfe_after_ctle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_o[4]) |-> $past(en_o[3]));

    // R9
    ctle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_o[3]) |-> ($past(en_o[2]) || ($past(en_o[6]) && $past(fail_i[6]))));
endmodule

bind rx_train_seq rx_train_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reinit_i  (reinit_i),
    .done_i    (done_i),
    .fail_i    (fail_i),
    .en_o      (en_o),
    .mode_o    (mode_o),
    .link_up_o (link_up_o)
);

// File: tb/rx_train_seq_bench.sv
// Directed bench for the training sequencer; engines are modelled by the
// bench driving done/fail pulses.
module rx_train_seq_bench;
    localparam int TW = 16;
    localparam int RW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0, retrain_i = 1'b0, reinit_i = 1'b0;
    logic [6:0]      done_i = '0, fail_i = '0;
    logic [7*TW-1:0] tmo_lim_i = '0;
    logic [RW-1:0]   retry_lim_i = '0;
    logic [6:0]      en_o;
    logic            ctle_hold_o, mode_o, link_up_o;
    logic [4:0]      status_o;

    int checks = 0;
    int fails  = 0;

    rx_train_seq #(.TW(TW), .RW(RW)) u_rx_train_seq (.*);

    always #4 clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_lim(input int ph, input int val);
        tmo_lim_i[ph*TW +: TW] = TW'(val);
    endtask

    task automatic pulse_done(input int ph);
        done_i[ph] = 1'b1; tick(); done_i = '0;
    endtask

    task automatic pulse_fail(input int ph);
        fail_i[ph] = 1'b1; tick(); fail_i = '0;
    endtask

    task automatic do_reinit();
        reinit_i = 1'b1; tick(); reinit_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 en", en_o, 0);
        chk("R1 link", {mode_o, link_up_o}, 0);
        chk("R1 status", status_o, 5'b00_000);
    endtask

    task automatic t_full_train();
        start_i = 1'b1; tick(); start_i = 1'b0;
        chk("R2 en", en_o, 7'b000_0001);
        chk("R2 status", status_o, 5'b01_000);
        pulse_done(0);
        chk("R3 plock", en_o, 7'b000_0010);
        // Done of a different phase, a start and a retrain are all ignored here
        done_i[4] = 1'b1; start_i = 1'b1; retrain_i = 1'b1; tick();
        done_i = '0; start_i = 1'b0; retrain_i = 1'b0;
        chk("R3 R2 R10 ignored", en_o, 7'b000_0010);
        for (int p = 1; p < 6; p++) begin
            pulse_done(p);
            chk("R4 en", en_o, 32'(1) << (p + 1));
            chk("R4 status", status_o, {2'b01, 3'(p + 1)});
            chk("R5 hold", ctle_hold_o, (p + 1 == 4) ? 1 : 0);
        end
        pulse_done(6);
        chk("R6 link", {link_up_o, mode_o}, 2'b11);
        chk("R6 en", en_o, 0);
        chk("R6 status", status_o, 5'b01_111);
        chk("R5 hold off", ctle_hold_o, 0);
    endtask

    task automatic t_timeout();
        do_reinit();
        chk("R11 from track", en_o, 7'b000_0001);
        pulse_done(0);
        for (int i = 0; i < 3; i++) tick();
        chk("R7 still waiting", en_o, 7'b000_0010);
        tick();
        chk("R7 timeout code", status_o, 5'b10_001);
        chk("R7 enables off", en_o, 0);
        // A done on the final cycle wins over the timeout
        do_reinit();
        pulse_done(0);
        for (int i = 0; i < 3; i++) tick();
        pulse_done(1);
        chk("R7 last-cycle done", en_o, 7'b000_0100);
    endtask

    task automatic t_engine_fail();
        done_i[2] = 1'b1; fail_i[2] = 1'b1; tick(); done_i = '0; fail_i = '0;
        chk("R8 fail code", status_o, 5'b11_010);
        chk("R8 link", link_up_o, 0);
        retrain_i = 1'b1; tick(); retrain_i = 1'b0;
        chk("R10 retrain from fail", en_o, 7'b000_0001);
    endtask

    task automatic t_verify_retry();
        retry_lim_i = 1;
        for (int p = 0; p < 6; p++) pulse_done(p);
        chk("R9 at verify", en_o, 7'b100_0000);
        pulse_fail(6);
        chk("R9 retry to ctle", en_o, 7'b000_1000);
        for (int p = 3; p < 6; p++) pulse_done(p);
        pulse_fail(6);
        chk("R9 exhausted", status_o, 5'b11_110);
        retrain_i = 1'b1; tick(); retrain_i = 1'b0;
        for (int p = 0; p < 6; p++) pulse_done(p);
        pulse_fail(6);
        chk("R10 retries cleared", en_o, 7'b000_1000);
    endtask

    task automatic t_reinit();
        // Currently in the peaking sweep: go to adaptation, then reinit plus done together
        pulse_done(3);
        done_i[4] = 1'b1; reinit_i = 1'b1; tick(); done_i = '0; reinit_i = 1'b0;
        chk("R11 override", en_o, 7'b000_0001);
        set_lim(0, 2);
        tick(); tick();
        do_reinit();
        tick(); tick();
        chk("R11 timer restart", en_o, 7'b000_0001);
        tick();
        chk("R11 R7 timeout", status_o, 5'b10_000);
    endtask

    initial begin
        for (int p = 0; p < 7; p++) set_lim(p, 20);
        set_lim(1, 3);
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_full_train();
        t_timeout();
        t_engine_fail();
        t_verify_retry();
        t_reinit();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule